// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the register file a processor core module uses for its identity, clock settings, memory configuration and a few board-level controls. A host reaches it over a simple synchronous word-addressed bus. Each cycle with the select input high is one access. A write takes effect at that clock edge. A read returns its word on the read-data output one cycle later, and the output holds that word until the next read.

The two oscillator words can only be changed while a 16-bit unlock key sits in the lock register. The lock register reports that state through an extra status bit on read. Two sticky flag words each have a set address and a clear address. A write to the control address moves a boot-alias remap output and an LED output, and updates selected bits of the init word. A read-only window returns the memory presence-detect bytes, one byte per word. Accesses to addresses with no register behind them raise a one-cycle error pulse.

Two small state machines hold the block's modes. The lock machine has the states LOCK_SHUT (reset) and LOCK_OPEN. A lock write carrying the key moves LOCK_SHUT to LOCK_OPEN, and a lock write carrying any other value moves LOCK_OPEN back to LOCK_SHUT. The map machine has the states MAP_ALIAS (reset; remap active) and MAP_DIRECT. A control write whose bit 2 differs from the stored init bit 2 moves MAP_ALIAS to MAP_DIRECT when the written bit is 1, and moves MAP_DIRECT to MAP_ALIAS when the written bit is 0. Every other cycle holds the current state.

Top module: `sysctl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000 and word 1 reads 0. Writes to these words change nothing.
- R2: A write to word 5 keeps only bits 15:0. A read of word 5 returns 0x0001A05F while the kept value is 0xA05F, and otherwise returns the kept value zero-extended.
- R3: A write to word 2 (oscillator) or word 7 (auxiliary oscillator) updates that word only while word 5 holds 0xA05F. At any other time the write is dropped.
- R4: After reset: word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, and words 5, 12 and 14 read 0. The remap output is 1, the LED output is 0, the error output is 0 and the read data is 0.
- R5: Word 8 resets to 0x00011122 ORed with a size code taken from parameter MEM_MB: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise (default 128 gives 0x0001112E). Word 8 is fully writable.
- R6: A write to word 12 ORs the data into the flag word, and a write to word 13 clears the bits set in the data. Words 14 and 15 do the same for a second, independent flag word. Reads of words 12 and 14 return the flag words, and reads of words 13 and 15 return 0.
- R7: A write to word 3 sets the LED output to data bit 0. If data bit 2 differs from init bit 2, the remap output becomes the inverse of data bit 2; otherwise the remap output holds. Init bits 0 and 2 become the inverse of data bits 0 and 2, and all other init bits keep their value.
- R8: A write to word 9 loads the whole init word and does not move the remap or LED outputs.
- R9: Words 64 to 95 read presence-detect byte k = word − 64 in bits 7:0. Byte 0 is 0x80, byte 10 is 0xA0, and byte 31 is the density code: 64, 32, 16, 4 or 2 for the same MEM_MB steps as R5. Words 96 to 127 read 0.
- R10: An access to any word other than 0–5, 7–9, 12–15 and 64–127 reads 0 and changes no state. Such an access raises the error output for exactly the following cycle.
- R11: Read data appears in the cycle after the read and reflects all earlier writes. It holds its value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Access strobe for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an access to an undefined word |
| remap_o | output | 1 | Boot-alias remap request, 1 = active |
| led_o | output | 1 | LED drive |

## Verification
A wrong lock state shows up in the very next read of word 5, because the status bit (bit 16) is missing or extra. It also shows up in the read of word 2 or 7 that follows a gated write. A map state that is out of step with the stored init bit 2 appears on remap_o one cycle after a control write, and usually only on the second write of a pair. For that reason the stimulus repeats control writes with equal and unequal bit 2. A flag word or an init word that has been corrupted appears on the first read of that word after the bad update, with a single cycle of read latency.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DW = 32;

    // word indices whose positions the host software decodes
    localparam int unsigned IX_ID       = 0;
    localparam int unsigned IX_PROC     = 1;
    localparam int unsigned IX_OSC      = 2;
    localparam int unsigned IX_CTRL     = 3;
    localparam int unsigned IX_STAT     = 4;
    localparam int unsigned IX_LOCK     = 5;
    localparam int unsigned IX_AUX      = 7;
    localparam int unsigned IX_SDRAM    = 8;
    localparam int unsigned IX_INIT     = 9;
    localparam int unsigned IX_FLAG_SET = 12;
    localparam int unsigned IX_FLAG_CLR = 13;
    localparam int unsigned IX_NV_SET   = 14;
    localparam int unsigned IX_NV_CLR   = 15;
    localparam int unsigned SPD_BASE_IX = 64;
    localparam int unsigned SPD_SPAN    = 64;
    localparam int unsigned SPD_BYTES   = 32;

    localparam logic [DW-1:0] ID_WORD    = 32'h411A_3001;
    localparam logic [DW-1:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [DW-1:0] OSC_RST    = 32'h0100_0048;
    localparam logic [DW-1:0] AUX_RST    = 32'h0007_FEFF;
    localparam logic [DW-1:0] SDRAM_BASE = 32'h0001_1122;
    localparam logic [DW-1:0] INIT_RST   = 32'h0000_0112;
    localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;

    localparam int unsigned REMAP_BIT = 2;
    localparam int unsigned LED_BIT   = 0;

    typedef enum logic {
        LOCK_SHUT = 1'b0,
        LOCK_OPEN = 1'b1
    } lock_state_e;

    typedef enum logic {
        MAP_ALIAS  = 1'b0,
        MAP_DIRECT = 1'b1
    } map_state_e;

    function automatic logic [DW-1:0] size_code(input int unsigned mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    function automatic logic [7:0] density(input int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    // presence-detect bytes; the last entry carries the density
    function automatic logic [7:0] spd_byte(input int unsigned k, input int unsigned mb);
        case (k)
            0:  return 8'd128;
            1:  return 8'd8;
            2:  return 8'd4;
            3:  return 8'd11;
            4:  return 8'd9;
            5:  return 8'd1;
            6:  return 8'd64;
            8:  return 8'd2;
            9:  return 8'hA0;
            10: return 8'hA0;
            13: return 8'd8;
            15: return 8'd1;
            16: return 8'h0E;
            17: return 8'd4;
            18: return 8'h1C;
            19: return 8'd1;
            20: return 8'd2;
            21: return 8'h20;
            22: return 8'hC0;
            27: return 8'h30;
            28: return 8'h28;
            29: return 8'h30;
            30: return 8'h28;
            31: return density(mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_i,
    input  logic [15:0] key_i,
    output logic [15:0] key_o,
    output logic        open_o
);

    lock_state_e state_q, state_d;
    logic [15:0] key_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LOCK_SHUT;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i) key_q <= key_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_SHUT: if (wr_i && key_i == UNLOCK_KEY) state_d = LOCK_OPEN;
            LOCK_OPEN: if (wr_i && key_i != UNLOCK_KEY) state_d = LOCK_SHUT;
            default:   state_d = LOCK_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        open_o = (state_q == LOCK_OPEN);
        key_o  = key_q;
    end

    // R2: the mode bit and the stored key never disagree
    p_state_key_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == LOCK_OPEN) == (key_q == UNLOCK_KEY));

    // R2: an open lock closes on any other written key
    p_close_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_o && wr_i && key_i != UNLOCK_KEY) |=> !open_o);

endmodule

// File: rtl/sysctl_flagpair.sv
module sysctl_flagpair #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      flags_q <= '0;
        else if (set_i) flags_q <= flags_q | data_i;
        else if (clr_i) flags_q <= flags_q & ~data_i;
    end

    assign flags_o = flags_q;

    // R6: set bits stick, cleared bits drop, idle holds
    p_set_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        set_i |=> (flags_o & $past(data_i)) == $past(data_i));

    p_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !set_i) |=> (flags_o & $past(data_i)) == '0);

    p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!set_i && !clr_i) |=> $stable(flags_o));

endmodule

// File: rtl/sysctl_remap.sv
module sysctl_remap
    import sysctl_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ctrl_wr_i,
    input  logic          init_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] init_o,
    output logic          remap_o,
    output logic          led_o
);

    map_state_e    state_q, state_d;
    logic [DW-1:0] init_q, init_d;
    logic          led_q;
    logic          bit_moves;

    assign bit_moves = ctrl_wr_i && (init_q[REMAP_BIT] != wdata_i[REMAP_BIT]);

    // state register and stored words
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= MAP_ALIAS;
            init_q  <= INIT_RST;
            led_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            init_q  <= init_d;
            if (ctrl_wr_i) led_q <= wdata_i[LED_BIT];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_ALIAS:  if (bit_moves &&  wdata_i[REMAP_BIT]) state_d = MAP_DIRECT;
            MAP_DIRECT: if (bit_moves && !wdata_i[REMAP_BIT]) state_d = MAP_ALIAS;
            default:    state_d = MAP_ALIAS;
        endcase
    end

    // init word update
    always_comb begin
        init_d = init_q;
        if (ctrl_wr_i) begin
            init_d[REMAP_BIT] = ~wdata_i[REMAP_BIT];
            init_d[LED_BIT]   = ~wdata_i[LED_BIT];
        end else if (init_wr_i) begin
            init_d = wdata_i;
        end
    end

    // outputs
    always_comb begin
        remap_o = (state_q == MAP_ALIAS);
        led_o   = led_q;
        init_o  = init_q;
    end

    // R7: remap moves only when the control bit differs from the stored one
    p_remap_move_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_moves |=> remap_o == !$past(wdata_i[REMAP_BIT]));

    p_remap_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_moves |=> $stable(remap_o));

    p_led_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_wr_i |=> led_o == $past(wdata_i[LED_BIT]));

    p_init_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_wr_i |=> (init_o[DW-1:3] == $past(init_o[DW-1:3])) && (init_o[1] == $past(init_o[1])));

    // R8: whole-word load of init
    p_init_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (init_wr_i && !ctrl_wr_i) |=> init_o == $past(wdata_i));

endmodule

// File: rtl/sysctl_spd.sv
module sysctl_spd
    import sysctl_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned MEM_MB = 128
) (
    input  logic [AW-1:0] idx_i,
    output logic          hit_o,
    output logic [DW-1:0] data_o
);

    localparam int unsigned   TW    = $clog2(SPD_BYTES);
    localparam logic [AW-1:0] BASE  = AW'(SPD_BASE_IX);
    localparam logic [AW-1:0] SPAN  = AW'(SPD_SPAN);
    localparam logic [AW-1:0] LIMIT = AW'(SPD_BYTES);

    logic [7:0]    tbl [SPD_BYTES];
    logic [AW-1:0] off;

    for (genvar g = 0; g < SPD_BYTES; g++) begin : g_tbl
        assign tbl[g] = spd_byte(g, MEM_MB);
    end

    always_comb begin
        off    = idx_i - BASE;
        hit_o  = (idx_i >= BASE) && (off < SPAN);
        data_o = '0;
        if (hit_o && off < LIMIT) data_o = {24'h0, tbl[off[TW-1:0]]};
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned MEM_MB = 128
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          sel_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          err_o,
    output logic          remap_o,
    output logic          led_o
);

    localparam logic [AW-1:0] A_ID    = AW'(IX_ID);
    localparam logic [AW-1:0] A_PROC  = AW'(IX_PROC);
    localparam logic [AW-1:0] A_OSC   = AW'(IX_OSC);
    localparam logic [AW-1:0] A_CTRL  = AW'(IX_CTRL);
    localparam logic [AW-1:0] A_STAT  = AW'(IX_STAT);
    localparam logic [AW-1:0] A_LOCK  = AW'(IX_LOCK);
    localparam logic [AW-1:0] A_AUX   = AW'(IX_AUX);
    localparam logic [AW-1:0] A_SDRAM = AW'(IX_SDRAM);
    localparam logic [AW-1:0] A_INIT  = AW'(IX_INIT);
    localparam logic [AW-1:0] A_FSET  = AW'(IX_FLAG_SET);
    localparam logic [AW-1:0] A_FCLR  = AW'(IX_FLAG_CLR);
    localparam logic [AW-1:0] A_NSET  = AW'(IX_NV_SET);
    localparam logic [AW-1:0] A_NCLR  = AW'(IX_NV_CLR);
    localparam logic [DW-1:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);
    localparam int unsigned   N_FLAGS = 2;

    logic          wr, rd;
    logic          wr_osc, wr_aux;
    logic          lock_open;
    logic [15:0]   lock_key;
    logic [DW-1:0] osc_q, aux_q, sdram_q;
    logic [DW-1:0] init_w;
    logic [DW-1:0] flag_w [N_FLAGS];
    logic          spd_hit;
    logic [DW-1:0] spd_data;
    logic          known;
    logic [DW-1:0] rd_d;
    logic [DW-1:0] rdata_q;
    logic          err_q;

    assign wr     = sel_i && we_i;
    assign rd     = sel_i && !we_i;
    assign wr_osc = wr && addr_i == A_OSC;
    assign wr_aux = wr && addr_i == A_AUX;

    sysctl_lock u_lock (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_i   (wr && addr_i == A_LOCK),
        .key_i  (wdata_i[15:0]),
        .key_o  (lock_key),
        .open_o (lock_open)
    );

    sysctl_remap u_remap (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctrl_wr_i (wr && addr_i == A_CTRL),
        .init_wr_i (wr && addr_i == A_INIT),
        .wdata_i   (wdata_i),
        .init_o    (init_w),
        .remap_o   (remap_o),
        .led_o     (led_o)
    );

    // flag word g: set at word 12+2g, clear at word 13+2g
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flags
        localparam logic [AW-1:0] A_SET = AW'(IX_FLAG_SET + 2 * g);
        localparam logic [AW-1:0] A_CLR = AW'(IX_FLAG_CLR + 2 * g);
        sysctl_flagpair #(.W(DW)) u_pair (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .set_i   (wr && addr_i == A_SET),
            .clr_i   (wr && addr_i == A_CLR),
            .data_i  (wdata_i),
            .flags_o (flag_w[g])
        );
    end

    sysctl_spd #(.AW(AW), .MEM_MB(MEM_MB)) u_spd (
        .idx_i  (addr_i),
        .hit_o  (spd_hit),
        .data_o (spd_data)
    );

    // plain storage words
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            osc_q   <= OSC_RST;
            aux_q   <= AUX_RST;
            sdram_q <= SDRAM_RST;
        end else begin
            if (wr_osc && lock_open) osc_q <= wdata_i;
            if (wr_aux && lock_open) aux_q <= wdata_i;
            if (wr && addr_i == A_SDRAM) sdram_q <= wdata_i;
        end
    end

    // decode and read mux
    always_comb begin
        known = spd_hit;
        rd_d  = '0;
        case (addr_i)
            A_ID:    begin known = 1'b1; rd_d = ID_WORD;   end
            A_PROC:  begin known = 1'b1; rd_d = '0;        end
            A_OSC:   begin known = 1'b1; rd_d = osc_q;     end
            A_CTRL:  begin known = 1'b1; rd_d = '0;        end
            A_STAT:  begin known = 1'b1; rd_d = STAT_WORD; end
            A_LOCK:  begin known = 1'b1; rd_d = {15'h0, lock_open, lock_key}; end
            A_AUX:   begin known = 1'b1; rd_d = aux_q;     end
            A_SDRAM: begin known = 1'b1; rd_d = sdram_q;   end
            A_INIT:  begin known = 1'b1; rd_d = init_w;    end
            A_FSET:  begin known = 1'b1; rd_d = flag_w[0]; end
            A_FCLR:  begin known = 1'b1; rd_d = '0;        end
            A_NSET:  begin known = 1'b1; rd_d = flag_w[1]; end
            A_NCLR:  begin known = 1'b1; rd_d = '0;        end
            default: rd_d = spd_data;
        endcase
    end

    // registered read port and error pulse
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd) rdata_q <= rd_d;
            err_q <= sel_i && !known;
        end
    end

    assign rdata_o = rdata_q;
    assign err_o   = err_q;

    // R3: a shut lock keeps both oscillator words
    p_osc_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_osc && !lock_open) |=> $stable(osc_q));

    p_aux_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_aux && !lock_open) |=> $stable(aux_q));

    // R10: an error pulse always follows an access
    p_err_cause_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> $past(sel_i));

    // R11: read data moves only after a read
    p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd |=> $stable(rdata_o));

    // R1: identification word
    p_id_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd && addr_i == A_ID) |=> rdata_o == ID_WORD);

endmodule

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 42;

    typedef struct packed {
        logic        chk;   // 1 = read and compare, 0 = write
        logic [7:0]  ix;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd0,   32'h411A3001, 4'd1},  // R1
        '{1'b1, 8'd4,   32'h00100000, 4'd1},  // R1
        '{1'b1, 8'd1,   32'h00000000, 4'd1},  // R1
        '{1'b1, 8'd2,   32'h01000048, 4'd4},  // R4
        '{1'b1, 8'd7,   32'h0007FEFF, 4'd4},  // R4
        '{1'b1, 8'd9,   32'h00000112, 4'd4},  // R4
        '{1'b1, 8'd5,   32'h00000000, 4'd4},  // R4
        '{1'b1, 8'd12,  32'h00000000, 4'd4},  // R4
        '{1'b1, 8'd8,   32'h0001112E, 4'd5},  // R5
        '{1'b0, 8'd2,   32'h12345678, 4'd3},  // R3 gated write
        '{1'b1, 8'd2,   32'h01000048, 4'd3},  // R3
        '{1'b0, 8'd5,   32'hFFFFA05F, 4'd2},  // R2
        '{1'b1, 8'd5,   32'h0001A05F, 4'd2},  // R2
        '{1'b0, 8'd2,   32'h12345678, 4'd3},  // R3
        '{1'b1, 8'd2,   32'h12345678, 4'd3},  // R3
        '{1'b0, 8'd7,   32'h0000AAAA, 4'd3},  // R3
        '{1'b1, 8'd7,   32'h0000AAAA, 4'd3},  // R3
        '{1'b0, 8'd5,   32'h00001234, 4'd2},  // R2
        '{1'b1, 8'd5,   32'h00001234, 4'd2},  // R2
        '{1'b0, 8'd7,   32'h00005555, 4'd3},  // R3
        '{1'b1, 8'd7,   32'h0000AAAA, 4'd3},  // R3
        '{1'b0, 8'd5,   32'h0000A05E, 4'd2},  // R2 near key
        '{1'b1, 8'd5,   32'h0000A05E, 4'd2},  // R2
        '{1'b0, 8'd12,  32'h000000F0, 4'd6},  // R6
        '{1'b0, 8'd12,  32'h0000000F, 4'd6},  // R6
        '{1'b1, 8'd12,  32'h000000FF, 4'd6},  // R6
        '{1'b0, 8'd13,  32'h000000F1, 4'd6},  // R6
        '{1'b1, 8'd12,  32'h0000000E, 4'd6},  // R6
        '{1'b0, 8'd14,  32'h80000001, 4'd6},  // R6
        '{1'b0, 8'd15,  32'h00000001, 4'd6},  // R6
        '{1'b1, 8'd14,  32'h80000000, 4'd6},  // R6
        '{1'b1, 8'd12,  32'h0000000E, 4'd6},  // R6 independent words
        '{1'b0, 8'd8,   32'h0000DEAD, 4'd5},  // R5
        '{1'b1, 8'd8,   32'h0000DEAD, 4'd5},  // R5
        '{1'b0, 8'd9,   32'hCAFEF00D, 4'd8},  // R8
        '{1'b1, 8'd9,   32'hCAFEF00D, 4'd8},  // R8
        '{1'b1, 8'd64,  32'h00000080, 4'd9},  // R9
        '{1'b1, 8'd74,  32'h000000A0, 4'd9},  // R9
        '{1'b1, 8'd95,  32'h00000020, 4'd9},  // R9 density 128 MB
        '{1'b1, 8'd96,  32'h00000000, 4'd9},  // R9
        '{1'b1, 8'd127, 32'h00000000, 4'd9},  // R9
        '{1'b1, 8'd13,  32'h00000000, 4'd6}   // R6 clear address reads 0
    };

    logic        clk, rst, sel, we;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] rdata;
    logic        err, remap, led;
    int          n_chk, n_err;
    bit          done;

    sysctl_regs i_sysctl_regs (
        .clk_i   (clk),
        .rst_i   (rst),
        .sel_i   (sel),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wd),
        .rdata_o (rdata),
        .err_o   (err),
        .remap_o (remap),
        .led_o   (led)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle; returns at the falling edge after the capturing edge
    task automatic access(input logic w, input logic [7:0] ix, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = w; addr = ix; wd = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        n_chk = 0; n_err = 0; done = 1'b0;
        rst = 1'b1; sel = 1'b0; we = 1'b0; addr = '0; wd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: outputs after reset
        check("R4 rdata", rdata, 32'h0);
        check("R4 err", {31'h0, err}, 32'h0);
        check("R4 remap", {31'h0, remap}, 32'h1);
        check("R4 led", {31'h0, led}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(~VECS[i].chk, VECS[i].ix, VECS[i].val);
            if (VECS[i].chk) check(rname(VECS[i].req), rdata, VECS[i].val);
        end

        // R7: control writes, init starts at 0xCAFEF00D (bit 2 = 1)
        access(1'b1, 8'd3, 32'h4);
        check("R7 remap held", {31'h0, remap}, 32'h1);
        check("R7 led", {31'h0, led}, 32'h0);
        access(1'b0, 8'd9, 32'h0);
        check("R7 init", rdata, 32'hCAFEF009);
        access(1'b1, 8'd3, 32'h4);
        check("R7 remap off", {31'h0, remap}, 32'h0);
        access(1'b1, 8'd3, 32'h1);
        check("R7 remap held", {31'h0, remap}, 32'h0);
        check("R7 led", {31'h0, led}, 32'h1);
        access(1'b0, 8'd9, 32'h0);
        check("R7 init", rdata, 32'hCAFEF00C);
        access(1'b1, 8'd3, 32'h1);
        check("R7 remap on", {31'h0, remap}, 32'h1);

        // R8: init load leaves outputs alone
        access(1'b1, 8'd9, 32'h0);
        check("R8 remap", {31'h0, remap}, 32'h1);
        check("R8 led", {31'h0, led}, 32'h1);
        access(1'b0, 8'd9, 32'h0);
        check("R8 init", rdata, 32'h0);

        // R10: undefined words
        access(1'b0, 8'd6, 32'h0);
        check("R10 rdata", rdata, 32'h0);
        check("R10 err", {31'h0, err}, 32'h1);
        @(negedge clk);
        check("R10 err pulse", {31'h0, err}, 32'h0);
        access(1'b1, 8'd40, 32'hFFFFFFFF);
        check("R10 err write", {31'h0, err}, 32'h1);
        access(1'b0, 8'd12, 32'h0);
        check("R10 flags untouched", rdata, 32'h0000000E);
        check("R10 no err", {31'h0, err}, 32'h0);
        access(1'b0, 8'd2, 32'h0);
        check("R10 osc untouched", rdata, 32'h12345678);

        // R1: write to identification ignored
        access(1'b1, 8'd0, 32'h0);
        access(1'b0, 8'd0, 32'h0);
        check("R1 id after write", rdata, 32'h411A3001);

        // R11: read data holds through idle and write cycles
        addr = 8'd4;
        @(negedge clk);
        check("R11 idle hold", rdata, 32'h411A3001);
        access(1'b1, 8'd8, 32'h1);
        check("R11 write hold", rdata, 32'h411A3001);
        access(1'b0, 8'd8, 32'h0);
        check("R11 after write", rdata, 32'h1);

        summary();
    end

endmodule